// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the bookkeeping of a write-through, write-allocate cache without holding any data. Each accepted request carries a byte address and a read or write flag. The block looks the address up among the stored tags of the selected set and answers hit or miss. On a miss it allocates a line in that set. It also keeps four statistics counters that count what a real memory behind the cache would have seen.

Block size, set count and ways per set are compile-time parameters, each a power of two, and the modelled cache size is their product. One set gives a fully associative cache and one way gives a direct-mapped cache. The replacement policy is chosen by a parameter. FIFO evicts the line filled longest ago, and LRU evicts the line touched longest ago. A synchronous clear empties the directory and zeroes the counters in one cycle.

Top module: `tagdir_cache`

## Requirements
- R1: The address is split from the least significant bit upward: log2(BLOCK_BYTES) offset bits, then log2(NUM_SETS) set-index bits, then the tag. Any two addresses in the same block hit each other. Addresses that differ in the tag or in the set index do not hit each other.
- R2: After reset every line is invalid, all four counters read zero and `rsp_valid_o` is low.
- R3: A read hit adds one to the hit counter and nothing else. A read miss adds one to the miss counter and one to the memory-read counter.
- R4: A write hit adds one to the hit counter and one to the memory-write counter. A write miss adds one each to the miss, memory-read and memory-write counters. Both kinds of miss allocate the block.
- R5: A miss fills an invalid line of its set, the lowest-numbered one, before any valid line is replaced.
- R6: With the FIFO policy (`REPL` = 0), the victim in a full set is the line filled least recently. Hits do not change that order.
- R7: With the LRU policy (`REPL` = 1), the victim in a full set is the line that was hit or filled least recently.
- R8: `req_ready_o` is high whenever `clear_i` is low. A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. Exactly one cycle after acceptance, `rsp_valid_o` is high for one cycle, with `rsp_hit_o` giving the result. At most one request is accepted per cycle.
- R9: While `clear_i` is high, `req_ready_o` is low and any request is ignored. After that edge all lines are invalid, all counters are zero and no response is pending.
- R10: Every counter saturates at 2^CNT_W − 1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous flush of lines and counters |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_addr_i | input | ADDR_W (48) | Byte address of the access |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | 1 = hit, 0 = miss |
| hit_count_o | output | CNT_W (32) | Hit counter |
| miss_count_o | output | CNT_W (32) | Miss counter |
| mem_rd_count_o | output | CNT_W (32) | Memory-read counter |
| mem_wr_count_o | output | CNT_W (32) | Memory-write counter |

## Verification
A stored tag or valid bit that is wrong shows up as a flipped `rsp_hit_o` on the next access to that block. The miss and memory-read counters then drift, both in the same cycle as the response. Replacement state that is wrong is harder to see, because it shows nothing until a set is full. The first visible symptom is a miss one or more requests after the eviction, when the line that should have survived is accessed again. For that reason the directed sequences fill a set and then probe every former resident. A FIFO instance and an LRU instance receive the same stream, so the two orderings are compared on identical traffic.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
    typedef enum logic [0:0] {
        REPL_FIFO = 1'b0,
        REPL_LRU  = 1'b1
    } repl_e;
endpackage

// File: rtl/tagdir_addr_split.sv
module tagdir_addr_split #(
    parameter int ADDR_W   = 48,
    parameter int OFF_W    = 4,
    parameter int SET_BITS = 2,
    parameter int SET_W    = 2,
    parameter int TAG_W    = 42
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SET_W-1:0]  set_o,
    output logic [TAG_W-1:0]  tag_o
);
    // byte offset within the block takes no part in the lookup
    logic unused_offset;
    assign unused_offset = ^addr_i[OFF_W-1:0];

    assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

    generate
        if (SET_BITS == 0) begin : g_one_set
            assign set_o = '0;
        end else begin : g_sets
            assign set_o = addr_i[OFF_W +: SET_BITS];
        end
    endgenerate
endmodule

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 42,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o,
    output logic                        free_o,
    output logic [WAY_W-1:0]            free_way_o,
    output logic [WAY_W-1:0]            victim_way_o
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAYS-1:0] match;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
        end
    endgenerate

    assign hit_o  = |match;
    assign free_o = ~&valid_i;

    // downward scans so the lowest index wins
    always_comb begin
        hit_way_o    = '0;
        free_way_o   = '0;
        victim_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])            hit_way_o    = WAY_W'(w);
            if (!valid_i[w])         free_way_o   = WAY_W'(w);
            if (ages_i[w] == OLDEST) victim_way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tagdir_age_update.sv
module tagdir_age_update #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages_i,
    input  logic [WAY_W-1:0]           way_i,
    output logic [WAYS-1:0][WAY_W-1:0] ages_o
);
    // touched way becomes youngest; younger ones age by one
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (ages_i[w] < ages_i[way_i]) ages_o[w] = ages_i[w] + 1'b1;
            else                           ages_o[w] = ages_i[w];
        end
        ages_o[way_i] = '0;
    end
endmodule

// File: rtl/tagdir_cache.sv
module tagdir_cache
    import tagdir_pkg::*;
#(
    parameter int    ADDR_W      = 48,
    parameter int    BLOCK_BYTES = 16,
    parameter int    NUM_SETS    = 4,
    parameter int    NUM_WAYS    = 2,
    parameter int    CNT_W       = 32,
    parameter repl_e REPL        = REPL_FIFO
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [CNT_W-1:0]  hit_count_o,
    output logic [CNT_W-1:0]  miss_count_o,
    output logic [CNT_W-1:0]  mem_rd_count_o,
    output logic [CNT_W-1:0]  mem_wr_count_o
);
    localparam int OFF_W    = $clog2(BLOCK_BYTES);
    localparam int SET_BITS = $clog2(NUM_SETS);
    localparam int SET_W    = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
    localparam int TAG_W    = ADDR_W - OFF_W - SET_BITS;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]             valid;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  tags;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0]  age;
        logic                                          rsp_valid;
        logic                                          rsp_hit;
        logic [CNT_W-1:0]                              hits;
        logic [CNT_W-1:0]                              misses;
        logic [CNT_W-1:0]                              mem_rd;
        logic [CNT_W-1:0]                              mem_wr;
    } state_t;

    function automatic state_t init_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_SETS; i++)
            for (int w = 0; w < NUM_WAYS; w++)
                s.age[i][w] = WAY_W'(w);
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    state_t st_q, st_d;

    logic [SET_W-1:0]                 set_idx;
    logic [TAG_W-1:0]                 tag;
    logic                             hit, free_found;
    logic [WAY_W-1:0]                 hit_way, free_way, victim_way;
    logic [WAY_W-1:0]                 fill_way, acc_way;
    logic [NUM_WAYS-1:0][WAY_W-1:0]   next_ages;
    logic                             accept;

    assign req_ready_o = !clear_i;
    assign accept      = req_valid_i && req_ready_o;

    tagdir_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_BITS(SET_BITS),
        .SET_W(SET_W), .TAG_W(TAG_W)
    ) u_split (
        .addr_i(req_addr_i), .set_o(set_idx), .tag_o(tag)
    );

    tagdir_lookup #(
        .WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_lookup (
        .valid_i      (st_q.valid[set_idx]),
        .tags_i       (st_q.tags[set_idx]),
        .ages_i       (st_q.age[set_idx]),
        .tag_i        (tag),
        .hit_o        (hit),
        .hit_way_o    (hit_way),
        .free_o       (free_found),
        .free_way_o   (free_way),
        .victim_way_o (victim_way)
    );

    assign fill_way = free_found ? free_way : victim_way;
    assign acc_way  = hit ? hit_way : fill_way;

    tagdir_age_update #(
        .WAYS(NUM_WAYS), .WAY_W(WAY_W)
    ) u_age (
        .ages_i (st_q.age[set_idx]),
        .way_i  (acc_way),
        .ages_o (next_ages)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        if (clear_i) begin
            st_d = init_state();
        end else if (accept) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_hit   = hit;
            if (hit) begin
                st_d.hits = sat_inc(st_q.hits);
            end else begin
                st_d.misses                   = sat_inc(st_q.misses);
                st_d.mem_rd                   = sat_inc(st_q.mem_rd);
                st_d.valid[set_idx][fill_way] = 1'b1;
                st_d.tags[set_idx][fill_way]  = tag;
            end
            if (req_write_i) st_d.mem_wr = sat_inc(st_q.mem_wr);
            // FIFO ages move on fills only, LRU ages on every access
            if (!hit || (REPL == REPL_LRU)) st_d.age[set_idx] = next_ages;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= init_state();
        else         st_q <= st_d;
    end

    assign rsp_valid_o    = st_q.rsp_valid;
    assign rsp_hit_o      = st_q.rsp_hit;
    assign hit_count_o    = st_q.hits;
    assign miss_count_o   = st_q.misses;
    assign mem_rd_count_o = st_q.mem_rd;
    assign mem_wr_count_o = st_q.mem_wr;
endmodule

// File: rtl/tagdir_cache_chk.sv
module tagdir_cache_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic             req_write_i,
    input logic             rsp_valid_o,
    input logic             rsp_hit_o,
    input logic [CNT_W-1:0] hit_count_o,
    input logic [CNT_W-1:0] miss_count_o,
    input logic [CNT_W-1:0] mem_rd_count_o,
    input logic [CNT_W-1:0] mem_wr_count_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_rsp_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> rsp_valid_o);

    assert_no_spurious_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

    assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (hit_count_o == '0 && miss_count_o == '0 &&
                     mem_rd_count_o == '0 && mem_wr_count_o == '0 && !rsp_valid_o));

    assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (hit_count_o >= $past(hit_count_o) &&
                      miss_count_o >= $past(miss_count_o) &&
                      mem_rd_count_o >= $past(mem_rd_count_o) &&
                      mem_wr_count_o >= $past(mem_wr_count_o)));

    assert_hit_no_mem_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_hit_o) |->
            (miss_count_o == $past(miss_count_o) && mem_rd_count_o == $past(mem_rd_count_o)));

    assert_reads_track_misses_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_count_o == miss_count_o);

    assert_write_counted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && req_write_i && mem_wr_count_o != TOP) |=>
            (mem_wr_count_o == $past(mem_wr_count_o) + 1'b1));
endmodule

bind tagdir_cache tagdir_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (clear_i),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_write_i    (req_write_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_hit_o      (rsp_hit_o),
    .hit_count_o    (hit_count_o),
    .miss_count_o   (miss_count_o),
    .mem_rd_count_o (mem_rd_count_o),
    .mem_wr_count_o (mem_wr_count_o)
);

// File: tb/tagdir_cache_bench.sv
module tagdir_cache_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, clear, req_valid, req_write;
    logic [47:0] req_addr;
    logic        a_ready, a_rv, a_hit, b_ready, b_rv, b_hit;
    logic [31:0] a_h, a_m, a_r, a_w;
    logic [5:0]  b_h, b_m, b_r, b_w;

    // A: 4 sets x 2 ways, 16-byte blocks, FIFO, 32-bit counters
    tagdir_cache u_tagdir_cache (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
        .req_ready_o(a_ready), .req_write_i(req_write), .req_addr_i(req_addr),
        .rsp_valid_o(a_rv), .rsp_hit_o(a_hit), .hit_count_o(a_h),
        .miss_count_o(a_m), .mem_rd_count_o(a_r), .mem_wr_count_o(a_w));

    // B: fully associative 4 ways, 8-byte blocks, LRU, 6-bit counters
    tagdir_cache #(.BLOCK_BYTES(8), .NUM_SETS(1), .NUM_WAYS(4), .CNT_W(6),
                   .REPL(tagdir_pkg::REPL_LRU)) u_lru (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
        .req_ready_o(b_ready), .req_write_i(req_write), .req_addr_i(req_addr),
        .rsp_valid_o(b_rv), .rsp_hit_o(b_hit), .hit_count_o(b_h),
        .miss_count_o(b_m), .mem_rd_count_o(b_r), .mem_wr_count_o(b_w));

    int checks = 0, fails = 0;

    int     m_sets[2] = '{4, 1};
    int     m_ways[2] = '{2, 4};
    int     m_off[2]  = '{4, 3};
    bit     m_lru[2]  = '{1'b0, 1'b1};
    longint m_max[2]  = '{64'hFFFF_FFFF, 63};
    bit          m_valid[2][16];
    logic [47:0] m_tag[2][16];
    int          m_fill[2][16];
    int          m_use[2][16];
    longint      m_cnt[2][4];   // hits, misses, reads, writes
    int          now = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 16; l++) m_valid[m][l] = 1'b0;
            for (int i = 0; i < 4; i++) m_cnt[m][i] = 0;
        end
    endtask

    task automatic bump(input int m, input int i);
        if (m_cnt[m][i] < m_max[m]) m_cnt[m][i]++;
    endtask

    task automatic model_access(input int m, input bit wr, input logic [47:0] a, output bit hit);
        logic [47:0] blk, tg;
        int set, pick, line;
        blk  = a >> m_off[m];
        set  = int'(blk % 48'(m_sets[m]));
        tg   = blk / 48'(m_sets[m]);
        hit  = 1'b0;
        pick = -1;
        for (int w = 0; w < m_ways[m]; w++) begin
            line = set * m_ways[m] + w;
            if (m_valid[m][line] && m_tag[m][line] == tg) begin hit = 1'b1; pick = line; end
        end
        if (hit) begin
            m_use[m][pick] = now;
            bump(m, 0);
        end else begin
            for (int w = 0; w < m_ways[m]; w++) begin
                line = set * m_ways[m] + w;
                if (pick < 0 && !m_valid[m][line]) pick = line;
            end
            if (pick < 0) begin
                pick = set * m_ways[m];
                for (int w = 1; w < m_ways[m]; w++) begin
                    line = set * m_ways[m] + w;
                    if (m_lru[m] ? (m_use[m][line] < m_use[m][pick])
                                 : (m_fill[m][line] < m_fill[m][pick])) pick = line;
                end
            end
            m_valid[m][pick] = 1'b1;
            m_tag[m][pick]   = tg;
            m_fill[m][pick]  = now;
            m_use[m][pick]   = now;
            bump(m, 1);
            bump(m, 2);
        end
        if (wr) bump(m, 3);
        now++;
    endtask

    function automatic string ctag(input int m, input int i);
        if (m_cnt[m][i] == m_max[m]) return "R10";
        return (i == 3) ? "R4" : "R3";
    endfunction

    task automatic check_counters();
        check(ctag(0,0), "A hits",   a_h, m_cnt[0][0]);
        check(ctag(0,1), "A misses", a_m, m_cnt[0][1]);
        check(ctag(0,2), "A reads",  a_r, m_cnt[0][2]);
        check(ctag(0,3), "A writes", a_w, m_cnt[0][3]);
        check(ctag(1,0), "B hits",   b_h, m_cnt[1][0]);
        check(ctag(1,1), "B misses", b_m, m_cnt[1][1]);
        check(ctag(1,2), "B reads",  b_r, m_cnt[1][2]);
        check(ctag(1,3), "B writes", b_w, m_cnt[1][3]);
    endtask

    task automatic do_req(input string tag, input bit wr, input logic [47:0] a);
        bit ha, hb;
        @(negedge clk);
        check("R8", "A idle rsp_valid", a_rv, 0);
        check("R8", "A ready", a_ready, 1);
        check("R8", "B ready", b_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        model_access(0, wr, a, ha);
        model_access(1, wr, a, hb);
        check("R8", "A rsp_valid", a_rv, 1);
        check("R8", "B rsp_valid", b_rv, 1);
        check(tag, "A hit", a_hit, ha);
        check(tag, "B hit", b_hit, hb);
        check_counters();
    endtask

    // clear with a request offered at the same time; that request is dropped
    task automatic do_clear(input logic [47:0] a);
        @(negedge clk);
        clear = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        #1;
        check("R9", "A ready during clear", a_ready, 0);
        check("R9", "B ready during clear", b_ready, 0);
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0; req_valid = 1'b0;
        model_reset();
        check("R9", "A rsp_valid after clear", a_rv, 0);
        check("R9", "B rsp_valid after clear", b_rv, 0);
        check_counters();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clear = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        check("R2", "A rsp_valid", a_rv, 0);
        check("R2", "B rsp_valid", b_rv, 0);
        check_counters();

        // R1: address fields
        do_req("R1", 1'b0, 48'h0000_0000_1230);
        do_req("R1", 1'b0, 48'h0000_0000_123F);
        do_req("R1", 1'b0, 48'h0000_0000_1240);
        do_req("R1", 1'b0, 48'hFFFF_0000_1230);
        do_req("R1", 1'b0, 48'h0000_0000_1234);
        // R4: write hit and write miss
        do_req("R4", 1'b1, 48'h0000_0000_1230);
        do_req("R4", 1'b1, 48'h0000_0000_5000);
        do_req("R4", 1'b0, 48'h0000_0000_5004);

        // R9: clear drops lines, counters and the concurrent request
        do_clear(48'h0000_0000_7770);
        do_req("R9", 1'b0, 48'h0000_0000_7770);
        do_req("R9", 1'b0, 48'h0000_0000_1230);

        // R5: free lines are used first, nothing valid is replaced
        do_clear(48'h0);
        do_req("R5", 1'b0, 48'h000);
        do_req("R5", 1'b0, 48'h040);
        do_req("R5", 1'b1, 48'h010);
        do_req("R5", 1'b0, 48'h050);
        do_req("R5", 1'b0, 48'h000);
        do_req("R5", 1'b0, 48'h040);
        do_req("R5", 1'b0, 48'h010);
        do_req("R5", 1'b1, 48'h050);
        // R6: FIFO in A set 0 ignores the hit on 0x000
        do_req("R6", 1'b0, 48'h000);
        do_req("R6", 1'b0, 48'h080);
        do_req("R6", 1'b0, 48'h040);
        do_req("R6", 1'b0, 48'h000);

        // R7: LRU in B, touching block 0 saves it, block 1 is evicted
        do_clear(48'h0);
        do_req("R7", 1'b0, 48'h000);
        do_req("R7", 1'b0, 48'h008);
        do_req("R7", 1'b0, 48'h010);
        do_req("R7", 1'b0, 48'h018);
        do_req("R7", 1'b0, 48'h000);
        do_req("R7", 1'b0, 48'h020);
        do_req("R7", 1'b0, 48'h000);
        do_req("R7", 1'b0, 48'h008);

        // random mix across few tags; B counters run into saturation
        for (int i = 0; i < 500; i++) begin
            logic [47:0] a;
            a = (48'($urandom_range(0, 2)) << 6) | (48'($urandom_range(0, 3)) << 4)
              | 48'($urandom_range(0, 15));
            if ($urandom_range(0, 9) == 0) a = a | 48'hABCD_0000_0000;
            do_req("R1", 1'(($urandom_range(0, 1))), a);
        end
        check("R10", "B misses held at max", b_m, 63);
        check("R10", "B reads held at max", b_r, 63);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule